// File: doc/BRIEF.md
# Processor Debug Event and Halt Controller

This block sits beside a processor core and watches the streams it exposes: the address of each instruction fetch, the address and value of each data access, and strobes for retirement, taken branches, traps, taken interrupts and returns. It also watches an external request pin. Each detected debug event sets a bit in a sticky status register. Software clears these bits by writing ones to them. When exceptions are enabled, any pending status bit raises an interrupt request toward the core.

The block can also stop the core. A soft stop waits until an instruction retires before it raises the halt request, and a resume strobe releases it. A hard stop raises the halt request combinationally, in the same cycle as an instruction or data address match. The hard halt then stays latched until reset. Two trace modes turn events into a stepping aid. Single-step makes every retirement an event and requests a soft stop after each one. Branch trace makes every taken branch an event.

Configuration goes through a small register port with synchronous writes and combinational reads.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: The status bits are: 0 instruction-address match (fetch valid and address equal to the instruction compare register), 1 data-address match, 2 trap, 3 taken branch, 4 retirement, 5 interrupt taken, 6 return, 7 external request. Each bit is set on the clock edge after its condition.
- R2: A status bit stays set until a write to the status register (address 1) has a 1 in that bit position. If an event and its clear arrive in the same cycle, the bit stays set.
- R3: Control bits [7:0] enable the eight sources by status-bit position. A disabled source sets no status bit.
- R4: With control bit 11 set, a data-address match also needs the data value to equal the data compare value register (address 4). With bit 11 clear, the value is ignored.
- R5: The interrupt request output is high exactly when control bit 8 (exception enable) is set and at least one status bit is set. It is therefore high on the cycle after an enabled event.
- R6: Control field [13:12] = 1 selects single-step. Every retirement then sets status bit 4 whatever bit 4 of the enable is, and halt request is high on the next cycle.
- R7: Control field [13:12] = 2 selects branch trace. Every taken branch then sets status bit 3 whatever its enable is, and no halt follows from it alone.
- R8: In soft-stop mode (control bit 9 set, bit 10 clear), an enabled event causes the halt request to rise on the cycle after the first retirement at or after the event. It never rises earlier.
- R9: While the core is soft-halted, a resume strobe drops the halt request on the next cycle and pulses the resume acknowledge high for exactly that one cycle. A resume strobe while running produces no acknowledge.
- R10: In hard-stop mode (control bits 9 and 10 set), an enabled address match raises the halt request in the same cycle. The halt request then stays high, ignoring resume, until reset.
- R11: Register addresses are 0 control, 1 status, 2 instruction compare address, 3 data compare address, 4 data compare value. All of them read back what was written (status reads the event bits), and all of them reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| i_vld | input | 1 | Instruction fetch address valid |
| i_addr | input | 32 | Instruction fetch address |
| d_vld | input | 1 | Data access valid |
| d_addr | input | 32 | Data access address |
| d_data | input | 32 | Data access value |
| retire | input | 1 | Instruction complete strobe |
| branch_taken | input | 1 | Taken branch strobe |
| trap | input | 1 | Trap strobe |
| intr_taken | input | 1 | Interrupt taken strobe |
| rtn | input | 1 | Return strobe |
| ext_req | input | 1 | External unconditional debug request |
| resume | input | 1 | Resume strobe from debugger |
| dbg_status | output | 8 | Sticky event status |
| dbg_irq | output | 1 | Debug exception request |
| halt_req | output | 1 | Halt request to the core |
| resume_ack | output | 1 | One-cycle acknowledge of an accepted resume |

## Verification
The bench builds the block with its defaults: 32-bit instruction and data addresses, a 32-bit data value and a 32-bit register port. These widths let the comparators be checked both on an exact match and on a near miss in the low address bits. The bench drives the instruction port combinationally between clock edges, which is how it reaches the same-cycle hard-stop halt. The pending soft-stop state is reached by holding an event with no retirement for several cycles. A simultaneous clear and event, the disabled sources and a resume while running are each driven at the ports and checked.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    localparam int NUM_EV = 8;

    // status bit positions
    localparam int EVB_IADDR  = 0;
    localparam int EVB_DADDR  = 1;
    localparam int EVB_TRAP   = 2;
    localparam int EVB_BRANCH = 3;
    localparam int EVB_RETIRE = 4;
    localparam int EVB_INTR   = 5;
    localparam int EVB_RTN    = 6;
    localparam int EVB_EXT    = 7;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_STAT   = 3'd1,
        RA_IMATCH = 3'd2,
        RA_DMATCH = 3'd3,
        RA_DVAL   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_SOFT = 2'd2,
        ST_HARD = 2'd3
    } stop_state_e;

    // control register layout, msb first
    typedef struct packed {
        logic [1:0]        trace;     // bit0 single-step, bit1 branch trace
        logic              val_qual;
        logic              hard_mode;
        logic              stop_en;
        logic              exc_en;
        logic [NUM_EV-1:0] src_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic retire;
        logic branch;
        logic trap;
        logic intr;
        logic rtn;
        logic ext;
    } strobe_t;

    function automatic logic [NUM_EV-1:0] trace_force(input logic [1:0] trace);
        logic [NUM_EV-1:0] f;
        f = '0;
        f[EVB_RETIRE] = trace[0];
        f[EVB_BRANCH] = trace[1];
        return f;
    endfunction

endpackage

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
    import dbg_halt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [NUM_EV-1:0] src_en,
    input  logic [1:0]        trace,
    input  logic              val_qual,
    input  logic [ADDR_W-1:0] imatch,
    input  logic [ADDR_W-1:0] dmatch,
    input  logic [DATA_W-1:0] dval,
    input  logic              i_vld,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic              d_vld,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DATA_W-1:0] d_data,
    input  strobe_t           stb,
    output logic [NUM_EV-1:0] det,
    output logic              addr_det,
    output logic              any_det,
    output logic              step_trig
);

    logic              i_hit;
    logic              d_hit;
    logic              v_hit;
    logic [NUM_EV-1:0] raw;
    logic [NUM_EV-1:0] en_eff;

    assign i_hit = i_vld && (i_addr == imatch);
    assign v_hit = (d_data == dval);
    assign d_hit = d_vld && (d_addr == dmatch) && (!val_qual || v_hit);

    always_comb begin
        raw             = '0;
        raw[EVB_IADDR]  = i_hit;
        raw[EVB_DADDR]  = d_hit;
        raw[EVB_TRAP]   = stb.trap;
        raw[EVB_BRANCH] = stb.branch;
        raw[EVB_RETIRE] = stb.retire;
        raw[EVB_INTR]   = stb.intr;
        raw[EVB_RTN]    = stb.rtn;
        raw[EVB_EXT]    = stb.ext;
    end

    assign en_eff = src_en | trace_force(trace);

    for (genvar g = 0; g < NUM_EV; g++) begin : g_gate
        assign det[g] = raw[g] & en_eff[g];
    end

    assign addr_det  = det[EVB_IADDR] | det[EVB_DADDR];
    assign any_det   = |det;
    assign step_trig = trace[0] & stb.retire;

endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
    import dbg_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] det,
    input  logic [NUM_EV-1:0] clr_mask,
    output logic [NUM_EV-1:0] stat
);

    for (genvar g = 0; g < NUM_EV; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat[g] <= 1'b0;
            end else if (det[g]) begin
                stat[g] <= 1'b1;
            end else if (clr_mask[g]) begin
                stat[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbg_stop_ctrl.sv
module dbg_stop_ctrl
    import dbg_halt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_en,
    input  logic hard_mode,
    input  logic any_det,
    input  logic addr_det,
    input  logic step_trig,
    input  logic retire,
    input  logic resume,
    output logic halt_req,
    output logic resume_ack,
    output logic hard_hold,
    output logic hard_now
);

    stop_state_e state_q;
    stop_state_e state_d;
    logic        trig;
    logic        ack_d;
    logic        ack_q;

    assign hard_now = stop_en && hard_mode && addr_det;
    assign trig     = (stop_en && any_det) || step_trig;

    always_comb begin
        state_d = state_q;
        ack_d   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hard_now)  state_d = ST_HARD;
                else if (trig) state_d = retire ? ST_SOFT : ST_PEND;
            end
            ST_PEND: begin
                if (hard_now)    state_d = ST_HARD;
                else if (retire) state_d = ST_SOFT;
            end
            ST_SOFT: begin
                if (hard_now) begin
                    state_d = ST_HARD;
                end else if (resume) begin
                    state_d = ST_RUN;
                    ack_d   = 1'b1;
                end
            end
            ST_HARD: state_d = ST_HARD;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
        end
    end

    assign hard_hold  = (state_q == ST_HARD);
    assign halt_req   = hard_hold || (state_q == ST_SOFT) || hard_now;
    assign resume_ack = ack_q;

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              i_vld,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic              d_vld,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DATA_W-1:0] d_data,
    input  logic              retire,
    input  logic              branch_taken,
    input  logic              trap,
    input  logic              intr_taken,
    input  logic              rtn,
    input  logic              ext_req,
    input  logic              resume,
    output logic [NUM_EV-1:0] dbg_status,
    output logic              dbg_irq,
    output logic              halt_req,
    output logic              resume_ack
);

    ctrl_t             ctl_q;
    logic [ADDR_W-1:0] imatch_q;
    logic [ADDR_W-1:0] dmatch_q;
    logic [DATA_W-1:0] dval_q;
    strobe_t           stb;
    logic [NUM_EV-1:0] det_vec;
    logic [NUM_EV-1:0] clr_mask;
    logic              addr_det;
    logic              any_det;
    logic              step_trig;
    logic              hard_hold;
    logic              hard_now;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            imatch_q <= '0;
            dmatch_q <= '0;
            dval_q   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL:   ctl_q    <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                RA_IMATCH: imatch_q <= reg_wdata[ADDR_W-1:0];
                RA_DMATCH: dmatch_q <= reg_wdata[ADDR_W-1:0];
                RA_DVAL:   dval_q   <= reg_wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    assign clr_mask = (reg_we && reg_addr == RA_STAT) ? reg_wdata[NUM_EV-1:0] : '0;

    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = REG_W'(ctl_q);
            RA_STAT:   reg_rdata = REG_W'(dbg_status);
            RA_IMATCH: reg_rdata = REG_W'(imatch_q);
            RA_DMATCH: reg_rdata = REG_W'(dmatch_q);
            RA_DVAL:   reg_rdata = REG_W'(dval_q);
            default:   reg_rdata = '0;
        endcase
    end

    always_comb begin
        stb.retire = retire;
        stb.branch = branch_taken;
        stb.trap   = trap;
        stb.intr   = intr_taken;
        stb.rtn    = rtn;
        stb.ext    = ext_req;
    end

    dbg_match_unit #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_match (
        .src_en    (ctl_q.src_en),
        .trace     (ctl_q.trace),
        .val_qual  (ctl_q.val_qual),
        .imatch    (imatch_q),
        .dmatch    (dmatch_q),
        .dval      (dval_q),
        .i_vld     (i_vld),
        .i_addr    (i_addr),
        .d_vld     (d_vld),
        .d_addr    (d_addr),
        .d_data    (d_data),
        .stb       (stb),
        .det       (det_vec),
        .addr_det  (addr_det),
        .any_det   (any_det),
        .step_trig (step_trig)
    );

    dbg_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .det      (det_vec),
        .clr_mask (clr_mask),
        .stat     (dbg_status)
    );

    assign dbg_irq = ctl_q.exc_en && (|dbg_status);

    dbg_stop_ctrl u_stop (
        .clk        (clk),
        .rst        (rst),
        .stop_en    (ctl_q.stop_en),
        .hard_mode  (ctl_q.hard_mode),
        .any_det    (any_det),
        .addr_det   (addr_det),
        .step_trig  (step_trig),
        .retire     (retire),
        .resume     (resume),
        .halt_req   (halt_req),
        .resume_ack (resume_ack),
        .hard_hold  (hard_hold),
        .hard_now   (hard_now)
    );

endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk
    import dbg_halt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input ctrl_t             ctl_q,
    input logic [NUM_EV-1:0] det_vec,
    input logic [NUM_EV-1:0] dbg_status,
    input logic              dbg_irq,
    input logic              retire,
    input logic              halt_req,
    input logic              resume_ack,
    input logic              hard_hold,
    input logic              hard_now
);

    p_event_sets_status_r2: assert property (@(posedge clk) disable iff (rst)
        (|det_vec) |=> ((dbg_status & $past(det_vec)) == $past(det_vec)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == 3'(RA_STAT))
        |=> ((dbg_status & $past(dbg_status)) == $past(dbg_status)));

    p_irq_follows_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.exc_en && (|det_vec) && !reg_we) |=> dbg_irq);

    p_soft_after_retire_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(halt_req) && !hard_now && !hard_hold) |-> $past(retire));

    p_hard_latched_r10: assert property (@(posedge clk) disable iff (rst)
        hard_hold |=> (hard_hold && halt_req));

    p_ack_after_halt_r9: assert property (@(posedge clk) disable iff (rst)
        resume_ack |-> $past(halt_req));

    p_ack_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        resume_ack |=> !resume_ack);

endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk u_chk (.*);

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        i_vld;
    logic [31:0] i_addr;
    logic        d_vld;
    logic [31:0] d_addr;
    logic [31:0] d_data;
    logic        retire, branch_taken, trap, intr_taken, rtn, ext_req, resume;
    logic [7:0]  dbg_status;
    logic        dbg_irq, halt_req, resume_ack;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dbg_halt_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .i_vld(i_vld), .i_addr(i_addr), .d_vld(d_vld), .d_addr(d_addr),
        .d_data(d_data), .retire(retire), .branch_taken(branch_taken),
        .trap(trap), .intr_taken(intr_taken), .rtn(rtn), .ext_req(ext_req),
        .resume(resume), .dbg_status(dbg_status), .dbg_irq(dbg_irq),
        .halt_req(halt_req), .resume_ack(resume_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        retire = 0; branch_taken = 0; trap = 0; intr_taken = 0;
        rtn = 0; ext_req = 0; resume = 0; i_vld = 0; d_vld = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        step();
        reg_we = 0; reg_addr = 3'd0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input logic [7:0] en, input bit exc, input bit stp,
                                        input bit hard, input bit qual, input logic [1:0] trc);
        return {18'd0, trc, qual, hard, stp, exc, en};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk(dbg_status == 8'h00, "R11 status after reset", 32'(dbg_status), 0);
        chk(!halt_req && !dbg_irq && !resume_ack, "R11 outputs after reset",
            {29'd0, halt_req, dbg_irq, resume_ack}, 0);
        rd(3'd0, v);
        chk(v == 0, "R11 control reset", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd2, 32'h0000_1000);
        wr(3'd3, 32'h0000_2000);
        wr(3'd4, 32'hCAFE_0001);
        rd(3'd2, v); chk(v == 32'h1000, "R11 instr compare readback", v, 32'h1000);
        rd(3'd3, v); chk(v == 32'h2000, "R11 data compare readback", v, 32'h2000);
        rd(3'd4, v); chk(v == 32'hCAFE_0001, "R11 value readback", v, 32'hCAFE_0001);
        wr(3'd0, ctl(8'hFF, 0, 0, 0, 0, 2'd0));
        rd(3'd0, v); chk(v == 32'h0FF, "R11 control readback", v, 32'h0FF);
    endtask

    task automatic t_sticky();
        trap = 1; step(); quiet();
        chk(dbg_status == 8'h04, "R1 trap sets bit 2", 32'(dbg_status), 32'h04);
        step();
        chk(dbg_status == 8'h04, "R2 bit stays set", 32'(dbg_status), 32'h04);
        chk(!dbg_irq, "R5 no irq while disabled", 32'(dbg_irq), 0);
        ext_req = 1; step(); quiet();
        chk(dbg_status == 8'h84, "R1 external request sets bit 7", 32'(dbg_status), 32'h84);
        wr(3'd1, 32'h04);
        chk(dbg_status == 8'h80, "R2 write-one clears only bit 2", 32'(dbg_status), 32'h80);
        intr_taken = 1;
        wr(3'd1, 32'hA0);
        quiet();
        chk(dbg_status == 8'h20, "R2 event beats same-cycle clear", 32'(dbg_status), 32'h20);
        wr(3'd1, 32'hFF);
    endtask

    task automatic t_enable();
        wr(3'd0, ctl(8'hBF, 0, 0, 0, 0, 2'd0));
        rtn = 1; step(); quiet();
        chk(dbg_status == 8'h00, "R3 disabled return sets nothing", 32'(dbg_status), 0);
        wr(3'd0, ctl(8'hFF, 0, 0, 0, 0, 2'd0));
        rtn = 1; step(); quiet();
        chk(dbg_status == 8'h40, "R1 enabled return sets bit 6", 32'(dbg_status), 32'h40);
        wr(3'd1, 32'hFF);
    endtask

    task automatic t_irq();
        wr(3'd0, ctl(8'hFF, 1, 0, 0, 0, 2'd0));
        chk(!dbg_irq, "R5 no irq with empty status", 32'(dbg_irq), 0);
        branch_taken = 1; step(); quiet();
        chk(dbg_irq && dbg_status == 8'h08, "R5 irq after enabled event",
            {23'd0, dbg_irq, dbg_status}, 32'h108);
        wr(3'd1, 32'hFF);
        chk(!dbg_irq, "R5 irq drops after clear", 32'(dbg_irq), 0);
        wr(3'd0, ctl(8'hFF, 0, 0, 0, 0, 2'd0));
    endtask

    task automatic t_iaddr();
        i_vld = 1; i_addr = 32'h1004; step(); quiet();
        chk(dbg_status == 8'h00, "R1 near-miss instr address", 32'(dbg_status), 0);
        i_vld = 1; i_addr = 32'h1000; step(); quiet();
        chk(dbg_status == 8'h01, "R1 instr address match", 32'(dbg_status), 32'h01);
        wr(3'd1, 32'hFF);
    endtask

    task automatic t_daddr();
        wr(3'd0, ctl(8'hFF, 0, 0, 0, 1, 2'd0));
        d_vld = 1; d_addr = 32'h2000; d_data = 32'hCAFE_0000; step(); quiet();
        chk(dbg_status == 8'h00, "R4 value mismatch blocks data match", 32'(dbg_status), 0);
        d_vld = 1; d_data = 32'hCAFE_0001; step(); quiet();
        chk(dbg_status == 8'h02, "R4 address and value match", 32'(dbg_status), 32'h02);
        wr(3'd1, 32'hFF);
        wr(3'd0, ctl(8'hFF, 0, 0, 0, 0, 2'd0));
        d_vld = 1; d_data = 32'h0; step(); quiet();
        chk(dbg_status == 8'h02, "R4 value ignored when unqualified", 32'(dbg_status), 32'h02);
        wr(3'd1, 32'hFF);
    endtask

    task automatic t_single_step();
        resume = 1; step(); quiet();
        chk(!resume_ack, "R9 no ack while running", 32'(resume_ack), 0);
        wr(3'd0, ctl(8'h00, 0, 0, 0, 0, 2'd1));
        retire = 1; step(); quiet();
        chk(halt_req && dbg_status == 8'h10, "R6 step event and halt",
            {23'd0, halt_req, dbg_status}, 32'h110);
        resume = 1; step(); quiet();
        chk(!halt_req && resume_ack, "R9 resume drops halt with ack",
            {30'd0, halt_req, resume_ack}, 32'h1);
        step();
        chk(!resume_ack && !halt_req, "R9 ack lasts one cycle",
            {30'd0, halt_req, resume_ack}, 0);
        wr(3'd1, 32'hFF);
    endtask

    task automatic t_branch_trace();
        wr(3'd0, ctl(8'h00, 0, 0, 0, 0, 2'd2));
        branch_taken = 1; step(); quiet();
        chk(dbg_status == 8'h08, "R7 branch trace sets bit 3", 32'(dbg_status), 32'h08);
        step();
        chk(!halt_req, "R7 branch trace alone does not halt", 32'(halt_req), 0);
        wr(3'd1, 32'hFF);
    endtask

    task automatic t_soft_stop();
        wr(3'd0, ctl(8'h04, 0, 1, 0, 0, 2'd0));
        trap = 1; step(); quiet();
        chk(!halt_req, "R8 no halt before retirement", 32'(halt_req), 0);
        step(); step();
        chk(!halt_req, "R8 still pending", 32'(halt_req), 0);
        retire = 1; step(); quiet();
        chk(halt_req, "R8 halt after retirement", 32'(halt_req), 1);
        resume = 1; step(); quiet();
        chk(!halt_req && resume_ack, "R9 soft stop released",
            {30'd0, halt_req, resume_ack}, 32'h1);
        wr(3'd1, 32'hFF);
    endtask

    task automatic t_hard_stop();
        wr(3'd0, ctl(8'h01, 0, 1, 1, 0, 2'd0));
        i_vld = 1; i_addr = 32'h1000;
        #0.5;
        chk(halt_req, "R10 halt in the match cycle", 32'(halt_req), 1);
        step(); quiet();
        chk(halt_req, "R10 halt latched", 32'(halt_req), 1);
        resume = 1; step(); quiet();
        step();
        chk(halt_req && !resume_ack, "R10 resume ignored",
            {30'd0, halt_req, resume_ack}, 32'h2);
        rst = 1; step(); rst = 0;
        chk(!halt_req && dbg_status == 0, "R10 reset leaves hard halt",
            {23'd0, halt_req, dbg_status}, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        i_addr = 0; d_addr = 0; d_data = 0;
        quiet();
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_regs();
        t_sticky();
        t_enable();
        t_irq();
        t_iaddr();
        t_daddr();
        t_single_step();
        t_branch_trace();
        t_soft_stop();
        t_hard_stop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule